// File: doc/BRIEF.md
# Patchable Step Sequencer

This block sequences a fixed-function datapath made of two ALUs and a multiplier. A program counter (PC) walks a hardwired schedule. Each step yields a control word, three 4-bit operation fields for ALU1, ALU2 and the multiplier, and a next-PC value. After fabrication, a small writable patch store can change how the controller moves through its steps. Match entries catch chosen hardwired PCs and replace both their control word and their next PC. PCs numbered above the patch base are extra steps whose contents come only from patch memory. A patch can therefore send a hardwired step into new steps and then rejoin the hardwired loop. The datapath units stay fixed: a patch only chooses which existing operations run in each step.

Software loads patches through a write port while the controller is idle. A start pulse launches one pass of the schedule. The pass ends when the selected next PC equals the terminal value, which is 1 by default. That step raises done, and the controller returns to idle with the PC back on step 1.

Top module: `ctl_patch_seq`

## Requirements
- R1: After reset the controller is idle (busy low), done is low, the PC reads 1, the control word output is 0, and every match entry is invalid.
- R2: A start pulse while idle sets busy on the next clock edge with the PC at 1. A start pulse while busy has no effect on the sequence.
- R3: With no patch loaded, one pass visits PCs 1, 2, 3. Hardwired step p drives the control word {p, p+8, 15-p} (4-bit fields: ALU1 in bits 11:8, ALU2 in bits 7:4, multiplier in bits 3:0). Its next PC is p+1, except that step 3 goes to 1.
- R4: Write address 0..7 loads patch word a, with data bits 15:12 as next PC and bits 11:0 as control word. Write address 8+i loads match entry i (i = 0..2), with data bits 3:0 as PC and bit 4 as valid. When the current PC equals a valid entry i, the step takes its control word and next PC from patch word i.
- R5: When several valid match entries hold the current PC, the lowest-numbered entry is used.
- R6: A PC greater than 3 (the patch base) takes its control word and next PC from patch word PC-1, so PCs 4..8 map to words 3..7.
- R7: A match entry hit takes priority over the above-base rule for the same PC.
- R8: An unmatched PC above 8 has no patch word. It drives control word 0 and a next PC equal to the terminal value, which ends the pass.
- R9: A write issued while busy changes neither the patch words nor the match entries.
- R10: Done is high for exactly the one step whose selected next PC is the terminal value 1. On the next edge busy falls and the PC returns to 1. While idle, done is low and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a pass when idle |
| busy_o | output | 1 | High while a pass is running |
| done_o | output | 1 | High during the last step of a pass |
| pc_o | output | 4 | Current program counter |
| cw_o | output | 12 | Control word to the datapath |
| wr_en_i | input | 1 | Patch write enable |
| wr_addr_i | input | 4 | Patch write address (0..7 words, 8..10 match entries) |
| wr_data_i | input | 16 | Patch write data |

## Verification
A corrupted match entry or patch word shows at the ports in the first step whose PC selects it: the control word is wrong in that same cycle, and pc_o shows the wrong step one cycle later. A wrong priority decision appears only when two sources cover one PC, so the scenarios stack entries on the same PC and put an entry on an above-base PC. A wrong state bit appears as early or missing done, or as busy staying high. Each pass is therefore checked step by step, through to the idle cycle that follows it.

// File: rtl/ctl_patch_pkg.sv
package ctl_patch_pkg;
   typedef enum logic {
      RUN_IDLE = 1'b0,
      RUN_BUSY = 1'b1
   } run_state_e;

   typedef enum logic [1:0] {
      SRC_ROM   = 2'd0,
      SRC_MATCH = 2'd1,
      SRC_EXT   = 2'd2,
      SRC_NONE  = 2'd3
   } step_src_e;
endpackage

// File: rtl/ctl_hw_rom.sv
module ctl_hw_rom #(
   parameter int PC_W     = 4,
   parameter int FLD_W    = 4,
   parameter int HW_STEPS = 3,
   parameter int FIRST_PC = 1,
   parameter int TERM_PC  = 1,
   localparam int CW_W    = 3 * FLD_W
) (
   input  logic [PC_W-1:0] pc_i,
   output logic [CW_W-1:0] cw_o,
   output logic [PC_W-1:0] nx_o
);
   localparam logic [FLD_W-1:0] HALF = FLD_W'(1) << (FLD_W - 1);
   localparam logic [FLD_W-1:0] ONES = '1;

   logic [FLD_W-1:0] p_fld;
   logic             in_range;

   assign p_fld    = FLD_W'(pc_i);
   assign in_range = (pc_i >= PC_W'(1)) && (pc_i <= PC_W'(HW_STEPS));

   always_comb begin
      cw_o = '0;
      nx_o = PC_W'(TERM_PC);
      if (in_range) begin
         cw_o = {p_fld, p_fld + HALF, ONES - p_fld};
         if (pc_i == PC_W'(HW_STEPS)) nx_o = PC_W'(FIRST_PC);
         else                         nx_o = pc_i + PC_W'(1);
      end
   end
endmodule

// File: rtl/ctl_patch_match.sv
module ctl_patch_match #(
   parameter int PC_W    = 4,
   parameter int N_MATCH = 3,
   localparam int IX_W   = (N_MATCH > 1) ? $clog2(N_MATCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [IX_W-1:0] wr_idx_i,
   input  logic [PC_W:0]   wr_ent_i,
   input  logic [PC_W-1:0] pc_i,
   output logic            hit_o,
   output logic [IX_W-1:0] hit_idx_o
);
   generate
      if (N_MATCH == 0) begin : g_none
         assign hit_o     = 1'b0;
         assign hit_idx_o = '0;
      end else begin : g_cmp
         logic [PC_W-1:0] ent_pc [N_MATCH];
         logic [N_MATCH-1:0] ent_vld;
         logic [N_MATCH-1:0] eq;

         for (genvar i = 0; i < N_MATCH; i++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  ent_pc[i]  <= '0;
                  ent_vld[i] <= 1'b0;
               end else if (we_i && wr_idx_i == IX_W'(i)) begin
                  ent_pc[i]  <= wr_ent_i[PC_W-1:0];
                  ent_vld[i] <= wr_ent_i[PC_W];
               end
            end
            assign eq[i] = ent_vld[i] && (ent_pc[i] == pc_i);
         end

         always_comb begin
            hit_o     = 1'b0;
            hit_idx_o = '0;
            for (int k = N_MATCH - 1; k >= 0; k--) begin
               if (eq[k]) begin
                  hit_o     = 1'b1;
                  hit_idx_o = IX_W'(k);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ctl_patch_mem.sv
module ctl_patch_mem #(
   parameter int WD_W  = 16,
   parameter int MEM_D = 8,
   localparam int MA_W = $clog2(MEM_D)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [MA_W-1:0] wr_idx_i,
   input  logic [WD_W-1:0] wr_word_i,
   input  logic [MA_W-1:0] rd_idx_i,
   output logic [WD_W-1:0] rd_word_o
);
   logic [WD_W-1:0] words [MEM_D];

   for (genvar w = 0; w < MEM_D; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 words[w] <= '0;
         else if (we_i && wr_idx_i == MA_W'(w))      words[w] <= wr_word_i;
      end
   end

   assign rd_word_o = words[rd_idx_i];
endmodule

// File: rtl/ctl_patch_seq.sv
module ctl_patch_seq #(
   parameter int PC_W       = 4,
   parameter int FLD_W      = 4,
   parameter int N_MATCH    = 3,
   parameter int MEM_D      = 8,
   parameter int HW_STEPS   = 3,
   parameter int PATCH_BASE = 3,
   parameter int FIRST_PC   = 1,
   parameter int TERM_PC    = 1,
   localparam int CW_W      = 3 * FLD_W,
   localparam int WD_W      = CW_W + PC_W,
   localparam int MA_W      = $clog2(MEM_D),
   localparam int AD_W      = MA_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [PC_W-1:0] pc_o,
   output logic [CW_W-1:0] cw_o,
   input  logic            wr_en_i,
   input  logic [AD_W-1:0] wr_addr_i,
   input  logic [WD_W-1:0] wr_data_i
);
   import ctl_patch_pkg::*;

   localparam int IX_W    = (N_MATCH > 1) ? $clog2(N_MATCH) : 1;
   localparam int EXT_CNT = MEM_D - N_MATCH;

   generate
      if ((1 << MA_W) != MEM_D) begin : g_bad_depth
         $error("MEM_D must be a power of two");
      end
      if (N_MATCH >= MEM_D) begin : g_bad_match
         $error("N_MATCH must be below MEM_D");
      end
      if (PATCH_BASE < HW_STEPS) begin : g_bad_base
         $error("PATCH_BASE must cover the hardwired steps");
      end
      if (FLD_W < PC_W) begin : g_bad_fld
         $error("FLD_W must hold a PC value");
      end
   endgenerate

   run_state_e        state_q;
   logic [PC_W-1:0]   pc_q;
   step_src_e         src;
   logic              wr_ok, mem_we, ent_we;
   logic              hit;
   logic [IX_W-1:0]   hit_idx;
   logic [CW_W-1:0]   rom_cw;
   logic [PC_W-1:0]   rom_nx;
   logic [PC_W:0]     ext_off;
   logic              above_base, ext_ok;
   logic [MA_W-1:0]   rd_idx;
   logic [WD_W-1:0]   rd_word;
   logic [CW_W-1:0]   sel_cw;
   logic [PC_W-1:0]   sel_nx;
   logic              last_step;

   // write decode: top address bit selects match entries
   assign wr_ok  = wr_en_i && (state_q == RUN_IDLE);
   assign mem_we = wr_ok && !wr_addr_i[AD_W-1];
   assign ent_we = wr_ok && wr_addr_i[AD_W-1] &&
                   ({1'b0, wr_addr_i[MA_W-1:0]} < (MA_W+1)'(N_MATCH));

   ctl_hw_rom #(
      .PC_W(PC_W), .FLD_W(FLD_W), .HW_STEPS(HW_STEPS),
      .FIRST_PC(FIRST_PC), .TERM_PC(TERM_PC)
   ) u_rom (
      .pc_i(pc_q), .cw_o(rom_cw), .nx_o(rom_nx)
   );

   ctl_patch_match #(.PC_W(PC_W), .N_MATCH(N_MATCH)) u_match (
      .clk(clk), .rst_n(rst_n), .we_i(ent_we),
      .wr_idx_i(IX_W'(wr_addr_i[MA_W-1:0])),
      .wr_ent_i(wr_data_i[PC_W:0]),
      .pc_i(pc_q), .hit_o(hit), .hit_idx_o(hit_idx)
   );

   ctl_patch_mem #(.WD_W(WD_W), .MEM_D(MEM_D)) u_mem (
      .clk(clk), .rst_n(rst_n), .we_i(mem_we),
      .wr_idx_i(wr_addr_i[MA_W-1:0]), .wr_word_i(wr_data_i),
      .rd_idx_i(rd_idx), .rd_word_o(rd_word)
   );

   // above-base steps map onto the words after the match words
   assign above_base = ({1'b0, pc_q} > (PC_W+1)'(PATCH_BASE));
   assign ext_off    = {1'b0, pc_q} - (PC_W+1)'(PATCH_BASE + 1);
   assign ext_ok     = above_base && (ext_off < (PC_W+1)'(EXT_CNT));

   always_comb begin
      if (hit)             src = SRC_MATCH;
      else if (ext_ok)     src = SRC_EXT;
      else if (above_base) src = SRC_NONE;
      else                 src = SRC_ROM;
   end

   always_comb begin
      case (src)
         SRC_MATCH: rd_idx = MA_W'(hit_idx);
         SRC_EXT:   rd_idx = MA_W'(ext_off) + MA_W'(N_MATCH);
         default:   rd_idx = '0;
      endcase
   end

   always_comb begin
      case (src)
         SRC_MATCH, SRC_EXT: begin
            sel_cw = rd_word[CW_W-1:0];
            sel_nx = rd_word[WD_W-1:CW_W];
         end
         SRC_NONE: begin
            sel_cw = '0;
            sel_nx = PC_W'(TERM_PC);
         end
         default: begin
            sel_cw = rom_cw;
            sel_nx = rom_nx;
         end
      endcase
   end

   assign last_step = (state_q == RUN_BUSY) && (sel_nx == PC_W'(TERM_PC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RUN_IDLE;
         pc_q    <= PC_W'(FIRST_PC);
      end else begin
         case (state_q)
            RUN_IDLE: begin
               pc_q <= PC_W'(FIRST_PC);
               if (start_i) state_q <= RUN_BUSY;
            end
            default: begin
               if (last_step) begin
                  state_q <= RUN_IDLE;
                  pc_q    <= PC_W'(FIRST_PC);
               end else begin
                  pc_q    <= sel_nx;
               end
            end
         endcase
      end
   end

   assign busy_o = (state_q == RUN_BUSY);
   assign done_o = last_step;
   assign pc_o   = pc_q;
   assign cw_o   = busy_o ? sel_cw : '0;
endmodule

// File: rtl/ctl_patch_chk.sv
module ctl_patch_chk #(
   parameter int PC_W     = 4,
   parameter int CW_W     = 12,
   parameter int FIRST_PC = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [PC_W-1:0] pc_o,
   input logic [CW_W-1:0] cw_o
);
   // R2: an idle start launches a pass at the first step
   a_r2_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && pc_o == PC_W'(FIRST_PC)));

   // R2: a running pass only stops through done
   a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R10: done is a single step, followed by idle at the first step
   a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o && pc_o == PC_W'(FIRST_PC)));

   // R10: no done and no control word while idle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!done_o && cw_o == '0));

   // R10: the PC stays on the first step while idle
   a_r10_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> (pc_o == PC_W'(FIRST_PC)));
endmodule

bind ctl_patch_seq ctl_patch_chk #(
   .PC_W(PC_W), .CW_W(CW_W), .FIRST_PC(FIRST_PC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .pc_o(pc_o), .cw_o(cw_o)
);

// File: tb/sim_ctl_patch_seq.sv
module sim_ctl_patch_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        busy_o, done_o;
   logic [3:0]  pc_o;
   logic [11:0] cw_o;
   logic        wr_en_i = 1'b0;
   logic [3:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [3:0]  exp_pc [8];
   logic [11:0] exp_cw [8];

   always #10 clk = ~clk;

   ctl_patch_seq u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
      .done_o(done_o), .pc_o(pc_o), .cw_o(cw_o), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
   );

   function automatic logic [11:0] hw_cw(input logic [3:0] p);
      return {p, p + 4'd8, 4'd15 - p};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // runs one pass of n steps against exp_pc / exp_cw
   task automatic run_expect(input int n, input string req);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int s = 0; s < n; s++) begin
         chk({req, " busy"}, 32'(busy_o), 32'd1);
         chk({req, " pc"}, 32'(pc_o), 32'(exp_pc[s]));
         chk({req, " cw"}, 32'(cw_o), 32'(exp_cw[s]));
         chk({req, " done"}, 32'(done_o), (s == n - 1) ? 32'd1 : 32'd0);
         if (s != n - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R10 idle busy", 32'(busy_o), 32'd0);
      chk("R10 idle pc", 32'(pc_o), 32'd1);
      chk("R10 idle cw", 32'(cw_o), 32'd0);
      chk("R10 idle done", 32'(done_o), 32'd0);
   endtask

   task automatic set_plain();
      for (int s = 0; s < 3; s++) begin
         exp_pc[s] = 4'(s + 1);
         exp_cw[s] = hw_cw(4'(s + 1));
      end
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy_o), 32'd0);
      chk("R1 done", 32'(done_o), 32'd0);
      chk("R1 pc", 32'(pc_o), 32'd1);
      chk("R1 cw", 32'(cw_o), 32'd0);
   endtask

   task automatic t_plain();
      set_plain();
      run_expect(3, "R3 plain");
   endtask

   task automatic t_busy_ignores();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 launch pc", 32'(pc_o), 32'd1);
      // R9: writes during the pass: entry0 on pc 2, word0 jumps to 3
      wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 16'h3ABC;
      @(negedge clk);
      wr_addr_i = 4'd8; wr_data_i = 16'h0012;
      chk("R2 step2 pc", 32'(pc_o), 32'd2);
      start_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; start_i = 1'b0;
      chk("R2 restart ignored pc", 32'(pc_o), 32'd3);
      chk("R2 done on step3", 32'(done_o), 32'd1);
      @(negedge clk);
      chk("R2 idle after pass", 32'(busy_o), 32'd0);
      set_plain();
      run_expect(3, "R9 writes while busy dropped");
   endtask

   task automatic t_redirect();
      wr(4'd0, {4'd4, 12'hA5A});
      wr(4'd3, {4'd3, 12'h3C3});
      wr(4'd8, 16'h0011);
      exp_pc[0] = 4'd1; exp_cw[0] = 12'hA5A;
      exp_pc[1] = 4'd4; exp_cw[1] = 12'h3C3;
      exp_pc[2] = 4'd3; exp_cw[2] = hw_cw(4'd3);
      run_expect(3, "R4 R6 redirect");
   endtask

   task automatic t_priority();
      wr(4'd1, {4'd3, 12'h111});
      wr(4'd2, {4'd3, 12'h222});
      wr(4'd9, 16'h0012);
      wr(4'd10, 16'h0012);
      wr(4'd8, 16'h0001);
      exp_pc[0] = 4'd1; exp_cw[0] = hw_cw(4'd1);
      exp_pc[1] = 4'd2; exp_cw[1] = 12'h111;
      exp_pc[2] = 4'd3; exp_cw[2] = hw_cw(4'd3);
      run_expect(3, "R5 lowest entry");
   endtask

   task automatic t_match_over_base();
      wr(4'd0, {4'd3, 12'h0F0});
      wr(4'd2, {4'd4, 12'h222});
      wr(4'd8, 16'h0014);
      wr(4'd10, 16'h0011);
      exp_pc[0] = 4'd1; exp_cw[0] = 12'h222;
      exp_pc[1] = 4'd4; exp_cw[1] = 12'h0F0;
      exp_pc[2] = 4'd3; exp_cw[2] = hw_cw(4'd3);
      run_expect(3, "R7 match over base");
   endtask

   task automatic t_beyond();
      wr(4'd2, {4'd9, 12'h777});
      exp_pc[0] = 4'd1; exp_cw[0] = 12'h777;
      exp_pc[1] = 4'd9; exp_cw[1] = 12'h000;
      run_expect(2, "R8 beyond memory");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_busy_ignores();
      t_redirect();
      t_priority();
      t_match_over_base();
      t_beyond();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule